// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block runs single read and write transfers on an external memory bus whose low address bits and data share one set of pins. An internal requester presents an address, write data, byte enables, a direction bit and a wait selector, and raises a request while the controller is idle. The controller then produces a fixed pin sequence. First, an address phase marks the address on the shared pins with ALE. Next comes a read or write strobe whose width scales with the chosen wait count. Last, a half-cycle tail holds chip select, the upper address and any write data. Read data is captured as the strobe ends and is returned together with a one-cycle done pulse.

The controller is clocked by an internal clock at twice the bus rate. Every bus pin changes on an edge of that clock, so each half bus cycle lasts exactly one internal cycle. The block also drives a bus clock output, which is restarted high at the start of each transfer. The wait selector picks n = 2 or n = 3. The strobe then lasts 2n−1 internal cycles, which is n − 0.5 bus cycles. A whole transfer takes 2n+2 internal cycles from acceptance to done.

A build parameter picks how writes are signalled: one common write strobe, or separate low-byte and high-byte strobes that follow the byte enables.

States:
- `S_IDLE`: waiting. Goes to `S_ALE` when a request is seen.
- `S_ALE`: ALE high with the address driven. Always goes to `S_AHOLD`.
- `S_AHOLD`: ALE low and the address still driven; the strobe timer is loaded. Always goes to `S_STROBE`.
- `S_STROBE`: the read or write strobe is active. Goes to `S_TAIL` when the timer reaches zero.
- `S_TAIL`: strobes released, holds kept, done pulsed. Always goes to `S_IDLE`.

Top module: `mxb_ctrl`

## Requirements
- R1: After reset and while idle: cs_n_o=1, ale_o=0, rd_n_o=1, wr_n_o=1, wrl_n_o=1, wrh_n_o=1, bhe_n_o=1, ad_oe_o=0, busy_o=0, done_o=0.
- R2: A request is accepted only in S_IDLE. busy_o is high from the cycle after acceptance through the done cycle. A request raised while busy_o is high starts no transfer.
- R3: ALE is high for exactly the first internal cycle after acceptance. The low address bits are driven on ad_o, with ad_oe_o=1, in both the first and the second cycle.
- R4: The strobe (rd_n_o or the write strobe) is low for 2n−1 consecutive internal cycles, starting in the third cycle after acceptance. n=2 when wait3_i=0 and n=3 when wait3_i=1.
- R5: On a read, ad_oe_o is 0 from strobe start through the tail. rdata_o holds the ad_i value present in the last strobe cycle, and is valid while done_o is high.
- R6: On a write, ad_o carries the write data with ad_oe_o=1 from strobe start through the tail cycle, which is one half bus cycle after the strobe rises.
- R7: cs_n_o stays low, and addr_hi_o keeps the upper address, for one internal cycle after the strobe deasserts. In the next cycle the bus returns to its idle levels.
- R8: bhe_n_o equals the inverse of byte enable bit 1 from acceptance through the tail cycle.
- R9: With SPLIT_WR=1, a write leaves wr_n_o high. wrl_n_o is low during the strobe only if be_i[0]=1, and wrh_n_o is low during the strobe only if be_i[1]=1. With SPLIT_WR=0, wrl_n_o and wrh_n_o stay high.
- R10: rd_n_o and any write strobe are never low in the same cycle. done_o is a one-cycle pulse in the cycle 2n+2 after acceptance.
- R11: bclk_o is 1 in the first cycle after acceptance and inverts on every internal clock edge without an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transfer request, sampled while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| wait3_i | input | 1 | 0 selects n=2, 1 selects n=3 |
| addr_i | input | AW | Transfer address |
| wdata_i | input | DW | Write data |
| be_i | input | DW/8 | Byte enables |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Captured read data |
| bclk_o | output | 1 | Bus clock |
| cs_n_o | output | 1 | Chip select, active low |
| ale_o | output | 1 | Address latch enable |
| ad_o | output | DW | Shared address/data out |
| ad_oe_o | output | 1 | Output enable for ad_o |
| ad_i | input | DW | Shared address/data in |
| addr_hi_o | output | AW-DW | Upper address lines |
| bhe_n_o | output | 1 | High byte enable, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Common write strobe, active low |
| wrl_n_o | output | 1 | Low-byte write strobe, active low |
| wrh_n_o | output | 1 | High-byte write strobe, active low |

## Verification
All pin levels decode directly from the state register. Cycle k after acceptance therefore shows the levels of phase k: address for k=1..2, strobe for k=3..2n+1, tail with done and rdata for k=2n+2, and idle for k=2n+3. Each scenario task raises the request on a falling edge and then samples every later falling edge. It compares the full pin vector against the phase expected for that k. The read bus input changes value around the last strobe cycle, so a capture on any other cycle shows up as wrong data.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ALE,
        S_AHOLD,
        S_STROBE,
        S_TAIL
    } mxb_state_t;
endpackage

// File: rtl/mxb_bclk_gen.sv
module mxb_bclk_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic bclk
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bclk <= 1'b0;
        else if (start) bclk <= 1'b1;
        else            bclk <= ~bclk;
    end

    // R11
    bclk_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (bclk != $past(bclk)));
endmodule

// File: rtl/mxb_strobe_timer.sv
module mxb_strobe_timer #(
    parameter int WAIT_LO = 2,
    parameter int WAIT_HI = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic hi_sel,
    input  logic run,
    output logic last
);
    localparam int CW = $clog2(2 * WAIT_HI);
    localparam logic [CW-1:0] LD_LO = CW'(2 * WAIT_LO - 2);
    localparam logic [CW-1:0] LD_HI = CW'(2 * WAIT_HI - 2);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= hi_sel ? LD_HI : LD_LO;
        else if (run && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/mxb_wr_strobe.sv
module mxb_wr_strobe #(
    parameter bit SPLIT_WR = 1'b0,
    parameter int BW       = 2
) (
    input  logic          wr_act,
    input  logic [BW-1:0] be,
    output logic          wr_n,
    output logic          wrl_n,
    output logic          wrh_n
);
    always_comb begin
        if (SPLIT_WR) begin
            wr_n  = 1'b1;
            wrl_n = !(wr_act && be[0]);
            wrh_n = !(wr_act && be[BW-1]);
        end else begin
            wr_n  = !wr_act;
            wrl_n = 1'b1;
            wrh_n = 1'b1;
        end
    end
endmodule

// File: rtl/mxb_ctrl.sv
module mxb_ctrl
    import mxb_pkg::*;
#(
    parameter int AW       = 20,
    parameter int DW       = 16,
    parameter int WAIT_LO  = 2,
    parameter int WAIT_HI  = 3,
    parameter bit SPLIT_WR = 1'b0,
    localparam int BW      = DW / 8,
    localparam int HW      = AW - DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          we_i,
    input  logic          wait3_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [BW-1:0] be_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] rdata_o,
    output logic          bclk_o,
    output logic          cs_n_o,
    output logic          ale_o,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe_o,
    input  logic [DW-1:0] ad_i,
    output logic [HW-1:0] addr_hi_o,
    output logic          bhe_n_o,
    output logic          rd_n_o,
    output logic          wr_n_o,
    output logic          wrl_n_o,
    output logic          wrh_n_o
);
    mxb_state_t state, nxt;

    logic          we_q, n3_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, rdata_q;
    logic [BW-1:0] be_q;
    logic          accept, tmr_last, wr_act;

    assign accept = (state == S_IDLE) && req_i;

    mxb_bclk_gen u_bclk (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .bclk  (bclk_o)
    );

    mxb_strobe_timer #(.WAIT_LO(WAIT_LO), .WAIT_HI(WAIT_HI)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (state == S_AHOLD),
        .hi_sel (n3_q),
        .run    (state == S_STROBE),
        .last   (tmr_last)
    );

    mxb_wr_strobe #(.SPLIT_WR(SPLIT_WR), .BW(BW)) u_wrs (
        .wr_act (wr_act),
        .be     (be_q),
        .wr_n   (wr_n_o),
        .wrl_n  (wrl_n_o),
        .wrh_n  (wrh_n_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (req_i) nxt = S_ALE;
            S_ALE:    nxt = S_AHOLD;
            S_AHOLD:  nxt = S_STROBE;
            S_STROBE: if (tmr_last) nxt = S_TAIL;
            S_TAIL:   nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // request capture and read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            n3_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                we_q    <= we_i;
                n3_q    <= wait3_i;
                addr_q  <= addr_i;
                wdata_q <= wdata_i;
                be_q    <= be_i;
            end
            if (state == S_STROBE && tmr_last && !we_q)
                rdata_q <= ad_i;
        end
    end

    assign rdata_o = rdata_q;

    // output decode
    always_comb begin
        busy_o    = 1'b1;
        done_o    = 1'b0;
        cs_n_o    = 1'b0;
        ale_o     = 1'b0;
        ad_o      = '0;
        ad_oe_o   = 1'b0;
        addr_hi_o = addr_q[AW-1:DW];
        bhe_n_o   = !be_q[BW-1];
        rd_n_o    = 1'b1;
        wr_act    = 1'b0;
        unique case (state)
            S_IDLE: begin
                busy_o    = 1'b0;
                cs_n_o    = 1'b1;
                addr_hi_o = '0;
                bhe_n_o   = 1'b1;
            end
            S_ALE: begin
                ale_o   = 1'b1;
                ad_o    = addr_q[DW-1:0];
                ad_oe_o = 1'b1;
            end
            S_AHOLD: begin
                ad_o    = addr_q[DW-1:0];
                ad_oe_o = 1'b1;
            end
            S_STROBE: begin
                rd_n_o  = we_q;
                wr_act  = we_q;
                ad_o    = we_q ? wdata_q : '0;
                ad_oe_o = we_q;
            end
            S_TAIL: begin
                done_o  = 1'b1;
                ad_o    = we_q ? wdata_q : '0;
                ad_oe_o = we_q;
            end
            default: begin
                busy_o  = 1'b0;
                cs_n_o  = 1'b1;
            end
        endcase
    end

    // R10
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && (!wr_n_o || !wrl_n_o || !wrh_n_o)));

    // R5
    rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !ad_oe_o);

    // R3
    ale_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> (!ale_o && !cs_n_o && ad_oe_o));

    // R7
    cs_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n_o) |-> !cs_n_o);

    // R2
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!busy_o && !done_o));
endmodule

// File: tb/mxb_ctrl_bench.sv
`timescale 1ns/1ps
module mxb_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, we_i = 1'b0, wait3_i = 1'b0;
    logic [19:0] addr_i = '0;
    logic [15:0] wdata_i = '0, ad_i = '0;
    logic [1:0]  be_i = '0;

    logic        busy_o, done_o, bclk_o, cs_n_o, ale_o, ad_oe_o, bhe_n_o;
    logic        rd_n_o, wr_n_o, wrl_n_o, wrh_n_o;
    logic [15:0] rdata_o, ad_o;
    logic [3:0]  addr_hi_o;

    logic        s_busy, s_done, s_bclk, s_cs_n, s_ale, s_oe, s_bhe_n;
    logic        s_rd_n, s_wr_n, s_wrl_n, s_wrh_n;
    logic [15:0] s_rdata, s_ad;
    logic [3:0]  s_hi;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    mxb_ctrl u_mxb_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .wait3_i(wait3_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .be_i(be_i), .busy_o(busy_o),
        .done_o(done_o), .rdata_o(rdata_o), .bclk_o(bclk_o), .cs_n_o(cs_n_o),
        .ale_o(ale_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ad_i(ad_i),
        .addr_hi_o(addr_hi_o), .bhe_n_o(bhe_n_o), .rd_n_o(rd_n_o),
        .wr_n_o(wr_n_o), .wrl_n_o(wrl_n_o), .wrh_n_o(wrh_n_o)
    );

    mxb_ctrl #(.SPLIT_WR(1'b1)) u_mxb_ctrl_split (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .wait3_i(wait3_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .be_i(be_i), .busy_o(s_busy),
        .done_o(s_done), .rdata_o(s_rdata), .bclk_o(s_bclk), .cs_n_o(s_cs_n),
        .ale_o(s_ale), .ad_o(s_ad), .ad_oe_o(s_oe), .ad_i(ad_i),
        .addr_hi_o(s_hi), .bhe_n_o(s_bhe_n), .rd_n_o(s_rd_n),
        .wr_n_o(s_wr_n), .wrl_n_o(s_wrl_n), .wrh_n_o(s_wrh_n)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] pins();
        return {cs_n_o, ale_o, rd_n_o, wr_n_o, wrl_n_o, wrh_n_o, bhe_n_o,
                ad_oe_o, busy_o, done_o, bclk_o};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle levels, bclk excluded
        check(pins()[10:1] == 10'b1_0_1_1_1_1_1_0_0_0, "R1 reset levels",
              32'(pins()[10:1]), 32'(10'b1011111000));
        check(s_wr_n && s_wrl_n && s_wrh_n && s_cs_n, "R1 split idle",
              {28'd0, s_cs_n, s_wr_n, s_wrl_n, s_wrh_n}, 32'hF);
    endtask

    task automatic t_txn(input bit we, input bit n3, input logic [19:0] a,
                         input logic [15:0] wd, input logic [1:0] be,
                         input logic [15:0] rdv);
        int n = n3 ? 3 : 2;
        @(negedge clk);
        req_i = 1'b1; we_i = we; wait3_i = n3; addr_i = a; wdata_i = wd; be_i = be;
        ad_i = ~rdv;
        for (int k = 1; k <= 2 * n + 3; k++) begin
            bit aph, stb, tl, act;
            logic [10:0] e;
            string tag;
            @(negedge clk);
            if (k == 1) req_i = 1'b0;
            aph = (k <= 2);
            stb = (k >= 3) && (k <= 2 * n + 1);
            tl  = (k == 2 * n + 2);
            act = aph || stb || tl;
            e = {!act, k == 1, !(stb && !we), !(stb && we), 1'b1, 1'b1,
                 act ? !be[1] : 1'b1, aph || (we && (stb || tl)), act, tl, k[0]};
            if (aph)      tag = "R3 R8 R11 address phase";
            else if (stb) tag = we ? "R4 R6 R10 write strobe" : "R4 R5 R10 read strobe";
            else if (tl)  tag = "R7 R10 tail";
            else          tag = "R7 R2 back to idle";
            check(pins() == e, tag, 32'(pins()), 32'(e));
            if (e[3])
                check(ad_o == (aph ? a[15:0] : wd), aph ? "R3 address on AD" : "R6 write data on AD",
                      32'(ad_o), 32'(aph ? a[15:0] : wd));
            if (act)
                check(addr_hi_o == a[19:16], "R7 upper address held",
                      32'(addr_hi_o), 32'(a[19:16]));
            if (we && act) begin
                logic [2:0] es = {1'b1, !(stb && be[0]), !(stb && be[1])};
                check({s_wr_n, s_wrl_n, s_wrh_n} == es, "R9 split write strobes",
                      32'({s_wr_n, s_wrl_n, s_wrh_n}), 32'(es));
            end
            if (tl && !we)
                check(rdata_o == rdv, "R5 read data captured", 32'(rdata_o), 32'(rdv));
            if (k == 2 * n + 1) ad_i = rdv;
            if (k == 2 * n + 2) ad_i = ~rdv;
        end
    endtask

    task automatic t_busy_ignore();
        @(negedge clk);
        req_i = 1'b1; we_i = 1'b1; wait3_i = 1'b0; addr_i = 20'h1_0040;
        wdata_i = 16'hBEEF; be_i = 2'b11;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k == 1) req_i = 1'b0;
            if (k == 3) begin req_i = 1'b1; addr_i = 20'hF_FFFE; end
            if (k == 5) req_i = 1'b0;
            check(busy_o == 1'b1, "R2 busy during transfer", 32'(busy_o), 32'd1);
        end
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(cs_n_o && !busy_o, "R2 request while busy ignored",
                  {30'd0, cs_n_o, busy_o}, 32'h2);
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!ended) begin
            ended = 1;
            fails++;
            checks++;
            $display("FAIL R2 watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_txn(1'b0, 1'b0, 20'hA_1234, 16'h0000, 2'b11, 16'h5A3C);
        t_txn(1'b0, 1'b1, 20'h3_8001, 16'h0000, 2'b01, 16'hC0DE);
        t_txn(1'b1, 1'b0, 20'h7_00F0, 16'h1357, 2'b11, 16'h0000);
        t_txn(1'b1, 1'b1, 20'h2_4444, 16'h9ABC, 2'b01, 16'h0000);
        t_txn(1'b1, 1'b0, 20'h5_0003, 16'h6543, 2'b10, 16'h0000);
        t_busy_ignore();
        t_txn(1'b0, 1'b1, 20'hE_FFFF, 16'h0000, 2'b10, 16'h0F0F);
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule